// File: doc/BRIEF.md
# Transmit-Active Hold and Station Address Register

This block sits beside a serial transmitter and a receive address filter. One 8-bit configuration word serves two purposes, and the split depends on the address mode. In the narrow mode, the low three bits hold the receive station address and the upper five bits hold a hold code. In the wide mode, all eight bits form the station address and there is no hold time.

While a frame is being sent, `tx_active` follows the transmitter's busy signal. When the last fill bit ends, `tx_active` stays high for the hold code times half a microsecond. The block derives that half-microsecond step from the system clock with its own divider. Received address bytes are compared against the stored address, and the result comes back as a one-cycle match flag.

Top module: `tx_hold_addr_reg`

## Requirements
- R1: While `rst_n` is low and `frame_busy` is low, `tx_active` and `addr_match` are both low.
- R2: `tx_active` is high in every cycle in which `frame_busy` is high.
- R3: In the narrow mode (`wide_addr_mode` = 0), the hold code is `cfg_word[7:3]`. After the clock edge that samples `last_fill`, `tx_active` stays high for exactly code × DIV_CYCLES clock cycles and then falls, with `frame_busy` low. Each such period is 0.5 µs at the default 50 MHz clock (DIV_CYCLES = 25), so the codes cover 0 µs to 15.5 µs. The count is taken from every `last_fill` edge, including one that arrives during an earlier hold.
- R4: With a hold code of 0, `tx_active` is low in the first cycle after the `last_fill` edge.
- R5: In the wide mode (`wide_addr_mode` = 1), no hold follows `last_fill`.
- R6: The hold code is captured at the `last_fill` edge. Changing `cfg_word` afterwards does not change the length of the running hold.
- R7: A cycle with `frame_busy` high and `last_fill` low cancels a running hold. Once `frame_busy` falls again, `tx_active` is low at once.
- R8: In the narrow mode, `addr_match` is high in the cycle after `rx_addr_valid` exactly when `rx_addr[2:0]` equals `cfg_word[2:0]`. Bits 7:3 of `rx_addr` are ignored.
- R9: In the wide mode, `addr_match` is high in the cycle after `rx_addr_valid` exactly when all eight bits of `rx_addr` equal `cfg_word`.
- R10: `addr_match` is low in any cycle that does not follow a cycle with `rx_addr_valid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 8 | Configuration word: hold code and address, or a full address |
| wide_addr_mode | input | 1 | 0 = 3-bit address plus hold code, 1 = 8-bit address |
| frame_busy | input | 1 | High while the transmitter is sending a frame |
| last_fill | input | 1 | One-cycle strobe at the end of the last fill bit |
| rx_addr_valid | input | 1 | A received address byte is present |
| rx_addr | input | 8 | Received address byte |
| tx_active | output | 1 | Transmit-active indication including the hold |
| addr_match | output | 1 | Registered station address match |

## Verification
The hardest situations to reach are the ones where events overlap a running hold: a second `last_fill` arriving partway through a hold, a new frame cancelling it, or a configuration change landing mid-hold. Each of these must be placed at a chosen cycle inside a hold that lasts hundreds of cycles. The bench therefore starts a hold and then waits a counted number of falling edges before applying the second event. Only after that does it measure how many cycles `tx_active` stays high. It compares that count with the code × 25 figure it computes from the configuration word.

// File: rtl/txah_pkg.sv
package txah_pkg;
  localparam int CFG_W    = 8;
  localparam int NARROW_W = 3;
  localparam int HOLD_W   = CFG_W - NARROW_W;

  // hold code carried by the configuration word; none in the wide mode
  function automatic logic [HOLD_W-1:0] hold_code_of(input logic [CFG_W-1:0] cfg,
                                                     input logic wide);
    return wide ? '0 : cfg[CFG_W-1:NARROW_W];
  endfunction

  // station address comparison, narrow mode looks at the low bits only
  function automatic logic addr_equal(input logic [CFG_W-1:0] rx,
                                      input logic [CFG_W-1:0] cfg,
                                      input logic wide);
    if (wide) return rx == cfg;
    return rx[NARROW_W-1:0] == cfg[NARROW_W-1:0];
  endfunction
endpackage

// File: rtl/txah_tick_div.sv
module txah_tick_div #(
  parameter int DIV_CYCLES = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int DIV_W = (DIV_CYCLES > 2) ? $clog2(DIV_CYCLES) : 1;

  logic [DIV_W-1:0] phase;

  assign tick = (phase == DIV_W'(DIV_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase <= '0;
    else if (restart)    phase <= '0;
    else if (tick)       phase <= '0;
    else                 phase <= phase + DIV_W'(1);
  end

  // step spacing behind the hold length of R3
  assert_tick_spaced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  assert_restart_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);
endmodule

// File: rtl/txah_hold_timer.sv
module txah_hold_timer
  import txah_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HOLD_W-1:0] load_code,
  input  logic              cancel,
  input  logic              tick,
  output logic              holding
);
  logic [HOLD_W-1:0] remaining;

  assign holding = (remaining != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      remaining <= '0;
    else if (load)                   remaining <= load_code;
    else if (cancel)                 remaining <= '0;
    else if (tick && holding)        remaining <= remaining - HOLD_W'(1);
  end

  assert_load_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_code != '0) |=> holding);
  assert_zero_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_code == '0) |=> !holding);
  assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && !load) |=> !holding);
  assert_no_growth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && holding) |=> remaining <= $past(remaining));
endmodule

// File: rtl/txah_addr_match.sv
module txah_addr_match
  import txah_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [CFG_W-1:0] rx_byte,
  input  logic [CFG_W-1:0] cfg,
  input  logic             wide,
  output logic             hit
);
  logic compare_now;

  assign compare_now = rx_valid && addr_equal(rx_byte, cfg, wide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit <= 1'b0;
    else        hit <= compare_now;
  end

  assert_hit_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(rx_valid));
  assert_narrow_low_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !wide && rx_byte[NARROW_W-1:0] != cfg[NARROW_W-1:0]) |=> !hit);
  assert_wide_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && wide && rx_byte == cfg) |=> hit);
endmodule

// File: rtl/tx_hold_addr_reg.sv
module tx_hold_addr_reg
  import txah_pkg::*;
#(
  parameter int DIV_CYCLES = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             wide_addr_mode,
  input  logic             frame_busy,
  input  logic             last_fill,
  input  logic             rx_addr_valid,
  input  logic [CFG_W-1:0] rx_addr,
  output logic             tx_active,
  output logic             addr_match
);
  logic              hold_load;
  logic              hold_cancel;
  logic [HOLD_W-1:0] hold_code;
  logic              half_us_tick;
  logic              holding;

  assign hold_load   = last_fill;
  assign hold_cancel = frame_busy && !last_fill;
  assign hold_code   = hold_code_of(cfg_word, wide_addr_mode);

  txah_tick_div #(.DIV_CYCLES(DIV_CYCLES)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (hold_load),
    .tick    (half_us_tick)
  );

  txah_hold_timer u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (hold_load),
    .load_code (hold_code),
    .cancel    (hold_cancel),
    .tick      (half_us_tick),
    .holding   (holding)
  );

  txah_addr_match u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_addr_valid),
    .rx_byte  (rx_addr),
    .cfg      (cfg_word),
    .wide     (wide_addr_mode),
    .hit      (addr_match)
  );

  assign tx_active = frame_busy || holding;

  assert_wide_no_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_fill && wide_addr_mode) |=> !holding);
  assert_hold_drives_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (last_fill && !wide_addr_mode && cfg_word[CFG_W-1:NARROW_W] != '0) |=> tx_active);
endmodule

// File: tb/tb_tx_hold_addr_reg.sv
`timescale 1ns/1ps
module tb_tx_hold_addr_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_word = 8'h00;
  logic       wide_addr_mode = 1'b0;
  logic       frame_busy = 1'b0;
  logic       last_fill = 1'b0;
  logic       rx_addr_valid = 1'b0;
  logic [7:0] rx_addr = 8'h00;
  logic       tx_active;
  logic       addr_match;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tx_hold_addr_reg dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .wide_addr_mode(wide_addr_mode),
    .frame_busy(frame_busy), .last_fill(last_fill), .rx_addr_valid(rx_addr_valid),
    .rx_addr(rx_addr), .tx_active(tx_active), .addr_match(addr_match)
  );

  typedef struct packed {
    logic       wide;
    logic [7:0] cfg;
    logic [7:0] rx;
    logic       valid;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 8'h05, 8'hFD, 1'b1},
    '{1'b0, 8'h1A, 8'h02, 1'b1},
    '{1'b0, 8'hFF, 8'h06, 1'b1},
    '{1'b0, 8'h0B, 8'h03, 1'b0},
    '{1'b1, 8'hA5, 8'hA5, 1'b1},
    '{1'b1, 8'hA5, 8'h25, 1'b1},
    '{1'b1, 8'h03, 8'h03, 1'b1},
    '{1'b0, 8'h83, 8'hA3, 1'b1}
  };

  function automatic int expect_hold(input logic wide, input logic [7:0] cfg);
    int code;
    code = wide ? 0 : int'(cfg / 8);
    return code * 25;
  endfunction

  function automatic int expect_match(input logic wide, input logic [7:0] cfg,
                                      input logic [7:0] rx, input logic valid);
    if (!valid) return 0;
    if (wide) return (rx == cfg) ? 1 : 0;
    return ((rx % 8) == (cfg % 8)) ? 1 : 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start_hold();
    @(negedge clk); last_fill = 1'b1; frame_busy = 1'b1;
    @(negedge clk); last_fill = 1'b0; frame_busy = 1'b0;
  endtask

  task automatic count_high(output int n);
    #1;
    n = 0;
    while (tx_active === 1'b1 && n < 5000) begin
      n++;
      @(negedge clk); #1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    #1;
    check("R1 tx_active in reset", int'(tx_active), 0);
    check("R1 addr_match in reset", int'(addr_match), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: busy drives tx_active
    @(negedge clk); frame_busy = 1'b1; #1;
    check("R2 busy active", int'(tx_active), 1);
    @(negedge clk); frame_busy = 1'b0; #1;
    check("R2 idle after busy", int'(tx_active), 0);

    // table walk: address match then hold length (R3 R4 R5 R8 R9 R10)
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wide_addr_mode = VECS[i].wide; cfg_word = VECS[i].cfg;
      rx_addr = VECS[i].rx; rx_addr_valid = VECS[i].valid;
      @(negedge clk); rx_addr_valid = 1'b0; #1;
      check(VECS[i].wide ? "R9 wide match" : "R8 narrow match",
            int'(addr_match), expect_match(VECS[i].wide, VECS[i].cfg, VECS[i].rx, VECS[i].valid));
      @(negedge clk); #1;
      check("R10 match drops", int'(addr_match), 0);
      start_hold();
      count_high(n);
      check(VECS[i].wide ? "R5 wide hold" : "R3 hold cycles", n,
            expect_hold(VECS[i].wide, VECS[i].cfg));
    end

    // R4: zero code drops at once
    @(negedge clk); wide_addr_mode = 1'b0; cfg_word = 8'h07;
    start_hold(); #1;
    check("R4 zero code", int'(tx_active), 0);

    // R6: config change during hold does not alter length
    @(negedge clk); cfg_word = 8'h20;
    start_hold();
    cfg_word = 8'hF8;
    count_high(n);
    check("R6 captured code", n, 100);

    // R3: a new last_fill mid-hold restarts with the new code
    @(negedge clk); cfg_word = 8'hA0;
    start_hold();
    repeat (37) @(negedge clk);
    cfg_word = 8'h10; last_fill = 1'b1; frame_busy = 1'b1;
    @(negedge clk); last_fill = 1'b0; frame_busy = 1'b0;
    count_high(n);
    check("R3 restart hold", n, 50);

    // R7: new frame cancels the hold
    @(negedge clk); cfg_word = 8'h50;
    start_hold();
    repeat (50) @(negedge clk);
    #1;
    check("R3 mid hold active", int'(tx_active), 1);
    frame_busy = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      check("R2 busy during cancel", int'(tx_active), 1);
    end
    frame_busy = 1'b0; #1;
    check("R7 cancelled", int'(tx_active), 0);
    repeat (30) @(negedge clk);
    #1;
    check("R7 stays low", int'(tx_active), 0);

    // R8: upper received bits ignored in narrow mode
    @(negedge clk); cfg_word = 8'h06; rx_addr = 8'hFE; rx_addr_valid = 1'b1;
    @(negedge clk); rx_addr_valid = 1'b0; #1;
    check("R8 upper bits ignored", int'(addr_match), 1);

    // R1: reset in the middle of a hold
    @(negedge clk); cfg_word = 8'hF8;
    start_hold();
    rst_n = 1'b0; #1;
    check("R1 reset clears hold", int'(tx_active), 0);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule